// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a memory-mapped watchdog. A 16-bit counter counts upward, one step per prescaled tick, and the prescale ratio comes from a fixed table of eight non-uniform ratios. When the counter steps past its all-ones value it wraps to zero. At that edge it raises a one-cycle reset request and sets a sticky overflow flag. The system reset that the request causes does not clear that flag, so boot firmware can read it and tell a watchdog reset from a cold start. Only the separate power-on reset input or an explicit software clear removes it.

Every write must carry a key in its upper bits, and a write with the wrong key does nothing. The counter register uses a 16-bit key and the two control registers share a 24-bit key. A new count does not take effect at once. It passes through a synchronisation delay measured in counting-clock pulses (`tick_en`). During that delay a status bit reads 1 and the counter keeps its old value. Software loads 65536 minus N, waits for the status bit to clear, and then sets the enable bit. The watchdog then times out after N prescaled ticks unless it is reloaded first.

Top module: `wdt_keyed`

## Requirements
- R1: A write to offset 0x0 changes the count only when bits 31:16 equal 0x5A5A. The new count is bits 15:0. A write to 0x0 with any other upper half has no effect on the count or on the pending bit.
- R2: A write to offset 0x4 or 0x8 takes effect only when bits 31:8 equal 0xA5A5A5. The payload is bits 7:0. A write with any other key leaves the register unchanged.
- R3: Control register (offset 0x4) layout:
  - bits 2:0: prescaler select.
  - bit 4: overflow flag.
  - bit 5: load-pending, read only.
  - bit 7: enable.
  - Bits 3 and 6 and bits 31:8 always read 0.
- R4: While enabled and not pending, the counter advances by one after every D pulses of `tick_en`. D is 1, 4, 16, 32, 64, 128, 1024 or 4096 for select 0 to 7. The prescaler restarts from zero whenever the timer is disabled or a load completes.
- R5: A keyed count write sets the pending bit. On the 3rd `tick_en` pulse after the write, the written value enters the counter and the pending bit clears. Until then the counter holds its old value and does not count. A new keyed write during the delay restarts the delay with the new value.
- R6: A step from 0xFFFF wraps the counter to 0, sets the overflow flag and drives `wd_reset_req` high for exactly one clock cycle.
- R7: The overflow flag survives `rst`. It is cleared by `por`, or by a keyed control write with bit 4 = 0. A keyed write with bit 4 = 1 leaves the flag unchanged.
- R8: After `por`, every readable register reads 0 and `wd_reset_req` is low.
- R9: Offset 0x8 is a plain 8-bit read/write register with no effect on counting. `rst` clears it.
- R10: `bus_rdata` is registered and reflects `bus_addr` from the previous cycle. The counter reads as {16'b0, count}. Unmapped offsets read 0.
- R11: While the enable bit is 0 and no load is pending, the counter holds its value whatever `tick_en` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; keeps the overflow flag |
| por | input | 1 | Synchronous active-high power-on reset; clears everything |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data including key |
| bus_rdata | output | 32 | Registered read data |
| tick_en | input | 1 | Counting-clock enable pulse |
| wd_reset_req | output | 1 | One-cycle reset request on overflow |

## Verification
The bench targets these corner cases. Each line says what a faulty design would show.
- **Pending window.** A design that loads on the first or second pulse would show the new count early. One that counts during the window would show a moved count.
- **Prescaler ratios.** It checks select 2 and select 7 one pulse below and one pulse at the ratio. A wrong table entry or an off-by-one compare shows up as an early or missing step.
- **Overflow flag.** It checks the flag across `rst`, across a write of 1 to bit 4, and under `por`. A flag tied to the common reset, or one that a write can set, would read wrongly.
- **Keys.** Writes with the wrong key, including the counter key sent to a control register, must leave the read-back value unchanged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 16;
  localparam int PRE_W   = 12;
  localparam logic [15:0] KEY_CNT = 16'h5A5A;
  localparam logic [23:0] KEY_CTL = 24'hA5A5A5;
  localparam int OFF_CNT  = 0;
  localparam int OFF_CTLA = 4;
  localparam int OFF_CTLB = 8;
  localparam int BIT_EN   = 7;
  localparam int BIT_PEND = 5;
  localparam int BIT_OVF  = 4;

  // terminal prescaler value (ratio - 1) for each select code
  function automatic logic [PRE_W-1:0] pre_limit(input logic [2:0] sel);
    logic [PRE_W:0] ratio;
    case (sel)
      3'd0: ratio = 13'd1;
      3'd1: ratio = 13'd4;
      3'd2: ratio = 13'd16;
      3'd3: ratio = 13'd32;
      3'd4: ratio = 13'd64;
      3'd5: ratio = 13'd128;
      3'd6: ratio = 13'd1024;
      default: ratio = 13'd4096;
    endcase
    pre_limit = PRE_W'(ratio - 13'd1);
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler import wdt_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       run,
  input  logic       tick,
  input  logic [2:0] sel,
  output logic       step
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim  = pre_limit(sel);
    step = run && tick && (pre_q >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      pre_q <= '0;
    else if (run && tick)
      pre_q <= (pre_q >= lim) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_load_sync.sv
module wdt_load_sync #(
  parameter int W          = 16,
  parameter int SYNC_TICKS = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wval,
  input  logic         tick,
  output logic         pending,
  output logic         load,
  output logic [W-1:0] lval
);
  localparam int DLY_W = (SYNC_TICKS < 2) ? 1 : $clog2(SYNC_TICKS + 1);

  logic [W-1:0] hold_q;
  always_ff @(posedge clk) begin
    if (rst)     hold_q <= '0;
    else if (wr) hold_q <= wval;
  end
  assign lval = hold_q;

  generate
    if (SYNC_TICKS == 0) begin : g_direct
      logic wr_q;
      always_ff @(posedge clk) begin
        if (rst) wr_q <= 1'b0;
        else     wr_q <= wr;
      end
      assign pending = 1'b0;
      assign load    = wr_q;
    end else begin : g_delay
      logic             pend_q;
      logic [DLY_W-1:0] dly_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q <= 1'b0;
          dly_q  <= '0;
        end else if (wr) begin
          pend_q <= 1'b1;
          dly_q  <= DLY_W'(SYNC_TICKS);
        end else if (pend_q && tick) begin
          dly_q <= dly_q - 1'b1;
          if (dly_q == DLY_W'(1)) pend_q <= 1'b0;
        end
      end
      assign pending = pend_q;
      assign load    = pend_q && tick && !wr && (dly_q == DLY_W'(1));
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] lval,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign wrap  = step && (&cnt_q);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= lval;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed import wdt_pkg::*; #(
  parameter int ADDR_W     = 4,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  output logic              wd_reset_req
);
  logic             srst;
  logic             cnt_wr, ctla_wr, ctlb_wr;
  logic             en_q, ovf_q, req_q;
  logic [2:0]       sel_q;
  logic [7:0]       regb_q;
  logic             pending, load, step, wrap;
  logic [CNT_W-1:0] lval, cnt_q;
  logic [DATA_W-1:0] rd_d, rd_q;

  assign srst = rst | por;

  always_comb begin
    cnt_wr  = bus_we && (bus_addr == ADDR_W'(OFF_CNT))  && (bus_wdata[31:16] == KEY_CNT);
    ctla_wr = bus_we && (bus_addr == ADDR_W'(OFF_CTLA)) && (bus_wdata[31:8]  == KEY_CTL);
    ctlb_wr = bus_we && (bus_addr == ADDR_W'(OFF_CTLB)) && (bus_wdata[31:8]  == KEY_CTL);
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      en_q   <= 1'b0;
      sel_q  <= 3'd0;
      regb_q <= 8'd0;
    end else begin
      if (ctla_wr) begin
        en_q  <= bus_wdata[BIT_EN];
        sel_q <= bus_wdata[2:0];
      end
      if (ctlb_wr) regb_q <= bus_wdata[7:0];
    end
  end

  wdt_load_sync #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS)) u_sync (
    .clk(clk), .rst(srst), .wr(cnt_wr), .wval(bus_wdata[CNT_W-1:0]),
    .tick(tick_en), .pending(pending), .load(load), .lval(lval)
  );

  wdt_prescaler u_pre (
    .clk(clk), .rst(srst), .clr(!en_q || load), .run(en_q && !pending),
    .tick(tick_en), .sel(sel_q), .step(step)
  );

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(srst), .load(load), .lval(lval), .step(step),
    .count(cnt_q), .wrap(wrap)
  );

  // sticky flag: only power-on reset clears it by reset
  always_ff @(posedge clk) begin
    if (por)                                 ovf_q <= 1'b0;
    else if (rst)                            ovf_q <= ovf_q;
    else if (wrap)                           ovf_q <= 1'b1;
    else if (ctla_wr && !bus_wdata[BIT_OVF]) ovf_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (srst) req_q <= 1'b0;
    else      req_q <= wrap;
  end
  assign wd_reset_req = req_q;

  always_comb begin
    rd_d = '0;
    if (bus_addr == ADDR_W'(OFF_CNT)) begin
      rd_d[CNT_W-1:0] = cnt_q;
    end else if (bus_addr == ADDR_W'(OFF_CTLA)) begin
      rd_d[BIT_EN]   = en_q;
      rd_d[BIT_PEND] = pending;
      rd_d[BIT_OVF]  = ovf_q;
      rd_d[2:0]      = sel_q;
    end else if (bus_addr == ADDR_W'(OFF_CTLB)) begin
      rd_d[7:0] = regb_q;
    end
  end

  always_ff @(posedge clk) begin
    if (srst) rd_q <= '0;
    else      rd_q <= rd_d;
  end
  assign bus_rdata = rd_q;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              por,
  input logic              tick_en,
  input logic              wd_reset_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [15:0]       count,
  input logic              ovf,
  input logic              pending,
  input logic              en
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst || por)
    wd_reset_req |=> !wd_reset_req); // R6
  AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst || por)
    wd_reset_req |-> (ovf && count == 16'h0)); // R6
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst || por)
    (pending && !tick_en) |=> $stable(count)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || por)
    (!en && !pending) |=> $stable(count)); // R11
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (por)
    rst |=> (ovf == $past(ovf))); // R7
  AST_CTLA_UPPER: assert property (@(posedge clk) disable iff (rst || por)
    (bus_addr == ADDR_W'(4)) |=> (bus_rdata[31:8] == 24'h0 && !bus_rdata[6] && !bus_rdata[3])); // R3
endmodule

bind wdt_keyed wdt_keyed_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .por(por), .tick_en(tick_en),
  .wd_reset_req(wd_reset_req), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .count(cnt_q), .ovf(ovf_q), .pending(pending), .en(en_q)
);

// File: tb/test_wdt_keyed.sv
`timescale 1ns/1ps
module test_wdt_keyed;
  localparam logic [31:0] KC = 32'h5A5A_0000;
  localparam logic [31:0] KA = 32'hA5A5_A500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        wd_reset_req;

  int n_chk = 0;
  int n_fail = 0;
  int req_seen = 0;
  bit done = 1'b0;
  logic rd_v = 1'b0;
  logic mon_v = 1'b0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  wdt_keyed i_wdt_keyed (
    .clk(clk), .rst(rst), .por(por), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .wd_reset_req(wd_reset_req)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop one cycle after a read was issued
  always @(posedge clk) mon_v <= rd_v;
  always @(negedge clk) begin
    if (mon_v && q_exp.size() > 0) check(bus_rdata, q_exp.pop_front(), q_tag.pop_front());
    if (wd_reset_req === 1'b1) req_seen++;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; q_exp.push_back(exp); q_tag.push_back(tag); rd_v = 1'b1;
    @(negedge clk);
    rd_v = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    por = 1'b0; rst = 1'b0;
    rd(4'h0, 32'h0, "R8 count");
    rd(4'h4, 32'h0, "R8 ctla");
    rd(4'h8, 32'h0, "R8 ctlb");
    rd(4'hC, 32'h0, "R10 unmapped");
    check(32'(wd_reset_req), 32'h0, "R8 req");

    wr(4'h8, KA | 32'h3C);          rd(4'h8, 32'h3C, "R9 ctlb rw");
    wr(4'h8, 32'h1234_5677);        rd(4'h8, 32'h3C, "R2 bad key");
    wr(4'h8, 32'h5A5A_0011);        rd(4'h8, 32'h3C, "R2 cnt key to ctlb");
    wr(4'h4, 32'h0000_0087);        rd(4'h4, 32'h0, "R2 unkeyed ctla");
    wr(4'h4, 32'h5A5A_0080);        rd(4'h4, 32'h0, "R2 cnt key to ctla");

    wr(4'h0, KC | 32'hFFF0);
    rd(4'h4, 32'h20, "R5 pending set");
    rd(4'h0, 32'h0, "R5 old count");
    tick(2);
    rd(4'h4, 32'h20, "R5 pending after 2");
    rd(4'h0, 32'h0, "R5 hold after 2");
    tick(1);
    rd(4'h4, 32'h0, "R5 pending clear");
    rd(4'h0, 32'hFFF0, "R5 loaded");

    wr(4'h0, 32'h0000_1234);
    rd(4'h4, 32'h0, "R1 no pending");
    tick(3);
    rd(4'h0, 32'hFFF0, "R1 unkeyed count");
    tick(5);
    rd(4'h0, 32'hFFF0, "R11 disabled");

    wr(4'h4, KA | 32'hE8);
    rd(4'h4, 32'h80, "R3 layout");
    tick(15);
    rd(4'h0, 32'hFFFF, "R4 div1");
    check(32'(req_seen), 32'd0, "R6 no early req");
    tick(1);
    rd(4'h0, 32'h0, "R6 wrap");
    rd(4'h4, 32'h90, "R6 flag set");
    check(32'(req_seen), 32'd1, "R6 one pulse");

    wr(4'h4, KA | 32'h12);
    rd(4'h4, 32'h12, "R7 write one keeps");
    wr(4'h0, KC | 32'hFFFE); tick(3);
    wr(4'h4, KA | 32'h92);
    tick(15); rd(4'h0, 32'hFFFE, "R4 div16 below");
    tick(1);  rd(4'h0, 32'hFFFF, "R4 div16 at");
    tick(16); rd(4'h0, 32'h0, "R4 div16 wrap");
    check(32'(req_seen), 32'd2, "R6 second pulse");

    wr(4'h4, KA | 32'h17);
    wr(4'h0, KC | 32'h0010); tick(3);
    wr(4'h4, KA | 32'h97);
    tick(4095); rd(4'h0, 32'h0010, "R4 div4096 below");
    tick(1);    rd(4'h0, 32'h0011, "R4 div4096 at");

    wr(4'h4, KA | 32'h90);
    wr(4'h0, KC | 32'h8000);
    tick(2); rd(4'h0, 32'h0011, "R5 running hold");
    tick(1); rd(4'h0, 32'h8000, "R5 running load");
    tick(1); rd(4'h0, 32'h8001, "R5 counts after load");
    wr(4'h0, KC | 32'h0100); tick(2);
    wr(4'h0, KC | 32'h0200); tick(2);
    rd(4'h0, 32'h8001, "R5 restart hold");
    tick(1); rd(4'h0, 32'h0200, "R5 restart value");

    wr(4'h4, KA | 32'h10);
    tick(4); rd(4'h0, 32'h0200, "R11 stopped");

    wr(4'h8, KA | 32'h5C);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(4'h4, 32'h10, "R7 survives rst");
    rd(4'h0, 32'h0, "R7 count cleared by rst");
    rd(4'h8, 32'h0, "R9 cleared by rst");

    wr(4'h4, KA);
    rd(4'h4, 32'h0, "R7 write zero clears");

    wr(4'h0, KC | 32'hFFFF); tick(3);
    wr(4'h4, KA | 32'h80); tick(1);
    rd(4'h4, 32'h90, "R6 flag again");
    check(32'(req_seen), 32'd3, "R6 third pulse");
    @(negedge clk); por = 1'b1;
    repeat (2) @(negedge clk); por = 1'b0;
    rd(4'h4, 32'h0, "R7 por clears");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule